// File: doc/BRIEF.md
# Reset Strap Latch and Management Address Match

This block captures a set of board-level configuration straps when the active-low reset is released. It holds the captured values until the next reset. From them it builds the default contents of the basic control register and the advertised speed capability. It also provides the wake-event output enable, a 5-bit management address and a decoded operating mode.

It also decides, for every incoming management frame, whether the frame is addressed to this device. Address zero normally acts as a broadcast address. A strap or a live software bit can turn it into an ordinary unique address.

The serial management protocol engine, pad drivers and pull resistors sit outside the block. The frame address and the software broadcast-disable bit are supplied by the neighbouring management logic.

Top module: `strap_cfg_unit`

## Requirements
- R1: On every rising clock edge with `rst_n` low, the captured fields load the current strap levels. Once `rst_n` is high, all captured fields and every output derived from them stay unchanged, whatever the straps do, until `rst_n` goes low again.
- R2: `dev_addr` equals the captured 3-bit address strap in bits [2:0], with bits [4:3] always 0. This gives addresses 0 to 7, and 1 with default pulls.
- R3: `ctrl_dflt` bit 13 and `adv_100` both equal the captured speed strap (1 = 100 Mb/s, 0 = 10 Mb/s).
- R4: `ctrl_dflt` bit 12 equals the captured negotiation-enable strap and bit 10 equals the captured isolate strap. Bit 8 is the inverse of the captured duplex strap, so strap high (half duplex) gives 0 and strap low gives 1 (full duplex). All other bits of `ctrl_dflt` are 0.
- R5: `wake_en` equals the captured wake-event enable strap (the default for bit 15 of the extended control register).
- R6: `bcast_en` is 1 only when the captured broadcast-off strap is 0 and the live `sw_bcast_dis` input is 0. `sw_bcast_dis` acts combinationally, with no capture.
- R7: `addr_match` is 1 whenever `frame_addr` equals `dev_addr`. This includes address 0 when it serves as the unique address.
- R8: When `frame_addr` is 0 and `bcast_en` is 1, `addr_match` is 1. When `frame_addr` differs from `dev_addr` and is not a broadcast hit, `addr_match` is 0.
- R9: The captured 3-bit mode strap code 000 gives `mode_valid`=1, `mode_b2b`=0 (normal). Code 110 gives `mode_valid`=1, `mode_b2b`=1 (back-to-back).
- R10: Every other mode code (001 to 101, 111) gives `mode_valid`=0 and `mode_b2b`=0, so the block falls back to normal behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are captured while low and held once high |
| strap_addr | input | 3 | Low management address straps |
| strap_mode | input | 3 | Operating-mode straps |
| strap_speed | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| strap_duplex | input | 1 | 1 = half duplex, 0 = full duplex |
| strap_aneg | input | 1 | Auto-negotiation enable |
| strap_iso | input | 1 | Isolate enable |
| strap_wake | input | 1 | Wake-event output enable |
| strap_bcast_off | input | 1 | 1 = address 0 is unique, not broadcast |
| sw_bcast_dis | input | 1 | Software broadcast disable, live |
| frame_addr | input | 5 | Address field of the incoming management frame |
| dev_addr | output | 5 | Device management address |
| ctrl_dflt | output | 16 | Default value for the basic control register |
| adv_100 | output | 1 | Advertised 100 Mb/s capability default |
| wake_en | output | 1 | Wake-event output enable default |
| bcast_en | output | 1 | Address 0 currently acts as broadcast |
| mode_valid | output | 1 | Captured mode code is a defined one |
| mode_b2b | output | 1 | Back-to-back mode selected |
| addr_match | output | 1 | Frame addressed to this device |

## Verification
The bench changes every strap right after reset release. A latch that tracked the pins, or sampled one cycle late, would show changed defaults.

It sweeps all 32 frame addresses under each combination of broadcast strap and software bit. This catches a design that lets software re-enable broadcast or that ignores the live bit. It also catches one that fails to match device address 0 once broadcast is off, or that compares only three address bits and aliases 8 to 31 onto the device.

Every one of the eight mode codes is captured in turn. A loose decode would then flag a reserved code as valid, or assert back-to-back for a neighbour of 110. The duplex polarity is checked in both directions.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int ADDR_W   = 5;
  localparam int STRAP_AW = 3;
  localparam int MODE_W   = 3;
  localparam int CREG_W   = 16;

  // bit positions decoded by the register file next door
  localparam int BIT_SPEED = 13;
  localparam int BIT_ANEG  = 12;
  localparam int BIT_ISO   = 10;
  localparam int BIT_DPLX  = 8;

  localparam logic [MODE_W-1:0] MODE_CODE_NORMAL = 3'b000;
  localparam logic [MODE_W-1:0] MODE_CODE_B2B    = 3'b110;

  typedef enum logic [1:0] {OPM_NORMAL, OPM_B2B, OPM_RESERVED} opmode_e;

  typedef struct packed {
    logic [STRAP_AW-1:0] addr;
    logic [MODE_W-1:0]   mode;
    logic                speed;
    logic                duplex;
    logic                aneg;
    logic                iso;
    logic                wake;
    logic                bcast_off;
  } strap_t;

  localparam int STRAP_W = $bits(strap_t);

  function automatic logic [CREG_W-1:0] ctrl_default(input strap_t s);
    logic [CREG_W-1:0] w;
    w            = '0;
    w[BIT_SPEED] = s.speed;
    w[BIT_ANEG]  = s.aneg;
    w[BIT_ISO]   = s.iso;
    w[BIT_DPLX]  = ~s.duplex;  // register bit set means full duplex
    return w;
  endfunction

  function automatic opmode_e decode_mode(input logic [MODE_W-1:0] code);
    if (code == MODE_CODE_NORMAL)   return OPM_NORMAL;
    else if (code == MODE_CODE_B2B) return OPM_B2B;
    else                            return OPM_RESERVED;
  endfunction

  function automatic logic [ADDR_W-1:0] full_addr(input logic [STRAP_AW-1:0] low);
    return {{(ADDR_W-STRAP_AW){1'b0}}, low};
  endfunction

  function automatic logic addr_hit(input logic [ADDR_W-1:0] fa,
                                    input logic [ADDR_W-1:0] own,
                                    input logic              bc_en);
    return (fa == own) || (bc_en && (fa == '0));
  endfunction
endpackage

// File: rtl/strap_sampler.sv
module strap_sampler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Follows the pins while reset is low; the last value seen is kept on release.
  always_ff @(posedge clk) begin
    if (!rst_n) q <= d;
  end

  a_r1_hold_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(q));
endmodule

// File: rtl/strap_mode_dec.sv
module strap_mode_dec
  import strap_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] code,
  output logic              mode_valid,
  output logic              mode_b2b
);
  opmode_e opm;

  always_comb begin
    opm        = decode_mode(code);
    mode_valid = (opm != OPM_RESERVED);
    mode_b2b   = (opm == OPM_B2B);
  end

  a_r9_b2b_only_for_code: assert property (@(posedge clk) disable iff (!rst_n)
    mode_b2b |-> (code == MODE_CODE_B2B));
  a_r10_reserved_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (code != MODE_CODE_NORMAL && code != MODE_CODE_B2B) |-> (!mode_valid && !mode_b2b));
endmodule

// File: rtl/mgmt_addr_match.sv
module mgmt_addr_match
  import strap_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] frame_addr,
  input  logic              bcast_off_latched,
  input  logic              sw_bcast_dis,
  output logic              bcast_en,
  output logic              hit
);
  always_comb begin
    bcast_en = !(bcast_off_latched || sw_bcast_dis);
    hit      = addr_hit(frame_addr, own_addr, bcast_en);
  end

  a_r6_sw_disables: assert property (@(posedge clk) disable iff (!rst_n)
    sw_bcast_dis |-> !bcast_en);
  a_r7_own_address: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_addr == own_addr) |-> hit);
  a_r8_foreign_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_addr != own_addr && frame_addr != '0) |-> !hit);
endmodule

// File: rtl/strap_cfg_unit.sv
module strap_cfg_unit
  import strap_cfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          strap_addr,
  input  logic [2:0]          strap_mode,
  input  logic                strap_speed,
  input  logic                strap_duplex,
  input  logic                strap_aneg,
  input  logic                strap_iso,
  input  logic                strap_wake,
  input  logic                strap_bcast_off,
  input  logic                sw_bcast_dis,
  input  logic [4:0]          frame_addr,
  output logic [4:0]          dev_addr,
  output logic [15:0]         ctrl_dflt,
  output logic                adv_100,
  output logic                wake_en,
  output logic                bcast_en,
  output logic                mode_valid,
  output logic                mode_b2b,
  output logic                addr_match
);
  strap_t pins_now;
  strap_t held;
  logic [STRAP_W-1:0] held_vec;

  always_comb begin
    pins_now.addr      = strap_addr;
    pins_now.mode      = strap_mode;
    pins_now.speed     = strap_speed;
    pins_now.duplex    = strap_duplex;
    pins_now.aneg      = strap_aneg;
    pins_now.iso       = strap_iso;
    pins_now.wake      = strap_wake;
    pins_now.bcast_off = strap_bcast_off;
  end

  strap_sampler #(.W(STRAP_W)) u_sampler (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_now),
    .q     (held_vec)
  );

  assign held = strap_t'(held_vec);

  always_comb begin
    dev_addr  = full_addr(held.addr);
    ctrl_dflt = ctrl_default(held);
    adv_100   = held.speed;
    wake_en   = held.wake;
  end

  strap_mode_dec u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .code       (held.mode),
    .mode_valid (mode_valid),
    .mode_b2b   (mode_b2b)
  );

  mgmt_addr_match u_match (
    .clk               (clk),
    .rst_n             (rst_n),
    .own_addr          (dev_addr),
    .frame_addr        (frame_addr),
    .bcast_off_latched (held.bcast_off),
    .sw_bcast_dis      (sw_bcast_dis),
    .bcast_en          (bcast_en),
    .hit               (addr_match)
  );

  a_r2_upper_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dev_addr[4:3] == 2'b00);
  a_r3_adv_tracks_speed: assert property (@(posedge clk) disable iff (!rst_n)
    adv_100 == ctrl_dflt[BIT_SPEED]);
  a_r8_broadcast_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_addr == '0 && bcast_en) |-> addr_match);
endmodule

// File: tb/strap_cfg_unit_bench.sv
module strap_cfg_unit_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic       rst_n = 1'b0;
  logic [2:0] strap_addr = 3'd1, strap_mode = 3'd0;
  logic strap_speed = 1, strap_duplex = 1, strap_aneg = 1, strap_iso = 0;
  logic strap_wake = 0, strap_bcast_off = 0, sw_bcast_dis = 0;
  logic [4:0] frame_addr = 5'd0;
  logic [4:0] dev_addr;
  logic [15:0] ctrl_dflt;
  logic adv_100, wake_en, bcast_en, mode_valid, mode_b2b, addr_match;

  strap_cfg_unit u_strap_cfg_unit (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .strap_mode(strap_mode),
    .strap_speed(strap_speed), .strap_duplex(strap_duplex), .strap_aneg(strap_aneg),
    .strap_iso(strap_iso), .strap_wake(strap_wake), .strap_bcast_off(strap_bcast_off),
    .sw_bcast_dis(sw_bcast_dis), .frame_addr(frame_addr), .dev_addr(dev_addr),
    .ctrl_dflt(ctrl_dflt), .adv_100(adv_100), .wake_en(wake_en), .bcast_en(bcast_en),
    .mode_valid(mode_valid), .mode_b2b(mode_b2b), .addr_match(addr_match)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // behavioural model: integers captured at each edge in reset
  int m_addr, m_mode, m_speed, m_duplex, m_aneg, m_iso, m_wake, m_boff;
  always @(posedge clk) if (!rst_n) begin
    m_addr = strap_addr; m_mode = strap_mode; m_speed = strap_speed;
    m_duplex = strap_duplex; m_aneg = strap_aneg; m_iso = strap_iso;
    m_wake = strap_wake; m_boff = strap_bcast_off;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int ctl, bc, hit, valid, b2b;
    ctl = 0;
    if (m_speed != 0) ctl += 8192;
    if (m_aneg != 0)  ctl += 4096;
    if (m_iso != 0)   ctl += 1024;
    if (m_duplex == 0) ctl += 256;
    bc  = (m_boff == 0 && sw_bcast_dis == 0) ? 1 : 0;
    hit = (int'(frame_addr) == m_addr || (frame_addr == 0 && bc == 1)) ? 1 : 0;
    valid = (m_mode == 0 || m_mode == 6) ? 1 : 0;
    b2b   = (m_mode == 6) ? 1 : 0;
    chk("R2 dev_addr", dev_addr, m_addr);
    chk("R3 R4 ctrl_dflt", ctrl_dflt, ctl);
    chk("R3 adv_100", adv_100, m_speed);
    chk("R5 wake_en", wake_en, m_wake);
    chk("R6 bcast_en", bcast_en, bc);
    chk("R7 R8 addr_match", addr_match, hit);
    chk("R9 R10 mode_valid", mode_valid, valid);
    chk("R9 R10 mode_b2b", mode_b2b, b2b);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic session(input int a, input int md, input int sp, input int dx,
                         input int an, input int is, input int wk, input int bo);
    strap_addr = 3'(a); strap_mode = 3'(md); strap_speed = sp[0];
    strap_duplex = dx[0]; strap_aneg = an[0]; strap_iso = is[0];
    strap_wake = wk[0]; strap_bcast_off = bo[0];
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1: pins move after release; held values must not
    strap_addr = ~strap_addr; strap_mode = ~strap_mode; strap_speed = ~strap_speed;
    strap_duplex = ~strap_duplex; strap_aneg = ~strap_aneg; strap_iso = ~strap_iso;
    strap_wake = ~strap_wake; strap_bcast_off = ~strap_bcast_off;
    for (int sw = 0; sw < 2; sw++) begin
      sw_bcast_dis = sw[0];
      for (int f = 0; f < 32; f++) begin
        frame_addr = 5'(f);
        step();
      end
    end
    sw_bcast_dis = 1'b0;
    frame_addr = 5'd0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected below 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // default pulls: address 1, normal mode, 100M, half duplex, negotiation on
    session(1, 0, 1, 1, 1, 0, 0, 0);
    // unique address 0 via strap, full duplex, back-to-back
    session(0, 6, 0, 0, 0, 1, 1, 1);
    // address 0 still broadcast, software turns it off in the sweep
    session(0, 6, 1, 0, 1, 1, 0, 0);
    // every mode code, including all reserved ones
    for (int m = 0; m < 8; m++)
      session(7 - m, m, m % 2, (m / 2) % 2, (m / 4) % 2, m % 2, (m + 1) % 2, m % 3 == 0);
    // R1: second reset picks up new values again
    session(5, 0, 0, 1, 0, 0, 1, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule